// File: doc/BRIEF.md
# Registered Parity Bus Transceiver

This block moves data both ways between two 18-bit ports, called A and B. Each port is split into two byte lanes of nine bits: eight data bits and one parity bit. There are two storage paths. The A-to-B path reads the A port and drives the B port. The B-to-A path reads the B port and drives the A port. Each path has its own clock, its own latch enable, an active-low clock enable for each lane, and its own output enable. Pins that would be three-state are split into separate input, output and output-enable signals.

When parity checking is enabled, each path checks the parity of the incoming lane words and raises an active-low error flag for each lane that fails. The outgoing parity bit is then generated from the stored byte, using a sense chosen by one odd/even control shared by both paths. When parity is switched off, the block is a plain 18-bit registered transceiver that passes parity bits through untouched.

Top module: `parity_xcvr`

## Requirements
- R1: Each port is two lanes. Lane k holds its data byte in bits [9k+7:9k] and its parity bit in bit 9k+8. Lane 0 is the low lane.
- R2: While a path's latch enable is high, its output follows its input port in the same cycle, without waiting for a clock edge.
- R3: While a path's latch enable is low, a lane whose active-low clock enable is 0 takes the input lane word on the rising edge of that path's clock.
- R4: While a path's latch enable is low, a lane whose clock enable is 1 keeps its stored word across clock edges. Each lane decides this on its own.
- R5: With par_off low, each outgoing parity bit is the XOR of that lane's stored byte when odd_sel is 0, and the inverse of that XOR when odd_sel is 1.
- R6: With par_off low, a lane's error output is 0 exactly when its incoming nine bits fail the selected sense. Even sense (odd_sel 0) fails when the XOR of the nine bits is 1. Odd sense (odd_sel 1) fails when it is 0.
- R7: With par_off high, outgoing parity bits equal the stored parity bits, and every error output stays 1.
- R8: A synchronous active-low reset clears all stored words to zero. While reset is held, every error output is 1.
- R9: b_oe follows ab_oe and a_oe follows ba_oe. dir_conflict is 1 exactly when both enables are 1.
- R10: The two paths are independent. Clocking or loading one path leaves the other path's stored contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Synchronous active-low reset, sampled by both path clocks |
| ab_clk | input | 1 | Clock of the A-to-B storage |
| ab_le | input | 1 | A-to-B latch enable (high = transparent) |
| ab_ce_n | input | 2 | A-to-B per-lane clock enable, active low |
| ab_oe | input | 1 | Enables driving of the B port |
| ba_clk | input | 1 | Clock of the B-to-A storage |
| ba_le | input | 1 | B-to-A latch enable (high = transparent) |
| ba_ce_n | input | 2 | B-to-A per-lane clock enable, active low |
| ba_oe | input | 1 | Enables driving of the A port |
| par_off | input | 1 | High turns parity generation and checking off |
| odd_sel | input | 1 | Parity sense: 0 even, 1 odd |
| a_in | input | 18 | Value seen on the A port |
| b_in | input | 18 | Value seen on the B port |
| a_out | output | 18 | Value driven onto the A port (B-to-A path) |
| a_oe | output | 1 | Output enable of the A port |
| b_out | output | 18 | Value driven onto the B port (A-to-B path) |
| b_oe | output | 1 | Output enable of the B port |
| a_err_n | output | 2 | Per-lane parity error on a_in, active low |
| b_err_n | output | 2 | Per-lane parity error on b_in, active low |
| dir_conflict | output | 1 | Both directions enabled together |

## Verification
The bench drives the same nine-bit words through both paths under even sense, odd sense and bypass. A design that swaps the sense would flag good words and accept bad ones, and a design that regenerates parity in bypass would alter the passed-through bits. With one lane's clock enable off and the other's on, it checks that only the enabled lane loads; shared enable wiring would move both lanes. Parity is also checked while the input is changing but storage holds, which exposes parity taken from the input instead of the stored byte. A final check confirms that error flags stay inactive under reset even when the incoming parity is bad.

// File: rtl/xcvr_pkg.sv
// Package: shared types of the registered parity transceiver.
// Assumes: parity sense is a single control bit, 0 = even, 1 = odd.
package xcvr_pkg;
    typedef enum logic {
        SENSE_EVEN = 1'b0,
        SENSE_ODD  = 1'b1
    } par_sense_e;
endpackage

// File: rtl/xcvr_lane_store.sv
// Module: xcvr_lane_store
// One lane word of storage. It is transparent while le is high and loads on the
// clock edge while ce_n is low. A synchronous active-low reset clears it.
// Assumes: le and ce_n are stable around the rising edge of clk.
module xcvr_lane_store #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic         ce_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] q_reg;

    // Storage: reset, then load while transparent or while clock-enabled
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_reg <= '0;
        else if (le || !ce_n)
            q_reg <= d;
    end

    // Output: while transparent, show the live input
    assign q = le ? d : q_reg;

    // R8
    rst_clear_chk: assert property (@(posedge clk) !rst_n |=> q_reg == '0);
    // R3
    lane_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (le || !ce_n) |=> q_reg == $past(d));
    // R4
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && ce_n) |=> $stable(q_reg));
endmodule

// File: rtl/xcvr_parity_lane.sv
// Module: xcvr_parity_lane
// Checks parity on one incoming lane word and builds the outgoing lane word from
// the stored word. The parity bit sits above the data byte.
// Assumes: par_off high bypasses both generation and checking.
module xcvr_parity_lane
    import xcvr_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic        rst_n,
    input  logic        par_off,
    input  logic        odd_sel,
    input  logic [DW:0] rx_word,
    input  logic [DW:0] st_word,
    output logic [DW:0] tx_word,
    output logic        err_n
);
    par_sense_e sense;
    logic       gen_bit;
    logic       mismatch;

    assign sense = par_sense_e'(odd_sel);

    // Generation: XOR of the stored byte, inverted for odd sense
    always_comb begin
        gen_bit = ^st_word[DW-1:0];
        if (sense == SENSE_ODD)
            gen_bit = ~gen_bit;
    end

    // Check: the 9-bit XOR must be 0 for even sense and 1 for odd sense
    always_comb begin
        mismatch = ^rx_word;
        if (sense == SENSE_ODD)
            mismatch = ~mismatch;
    end

    // Output word: pass through in bypass, otherwise swap in the generated bit
    assign tx_word = par_off ? st_word : {gen_bit, st_word[DW-1:0]};
    // Error flag: active low, masked by bypass and by reset
    assign err_n   = ~(mismatch & ~par_off & rst_n);
endmodule

// File: rtl/xcvr_dir.sv
// Module: xcvr_dir
// One direction of the transceiver: per-lane storage followed by per-lane parity
// generation, plus per-lane checking of the incoming port.
// Assumes: lane k occupies bits [k*(DW+1) +: DW+1], with parity in the top bit.
module xcvr_dir #(
    parameter int unsigned DW    = 8,
    parameter int unsigned LANES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      le,
    input  logic [LANES-1:0]          ce_n,
    input  logic                      par_off,
    input  logic                      odd_sel,
    input  logic [LANES*(DW+1)-1:0]   rx,
    output logic [LANES*(DW+1)-1:0]   tx,
    output logic [LANES-1:0]          err_n
);
    localparam int unsigned LW = DW + 1;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LW-1:0] st;

        xcvr_lane_store #(.W(LW)) u_store (
            .clk  (clk),
            .rst_n(rst_n),
            .le   (le),
            .ce_n (ce_n[k]),
            .d    (rx[k*LW +: LW]),
            .q    (st)
        );

        xcvr_parity_lane #(.DW(DW)) u_par (
            .rst_n  (rst_n),
            .par_off(par_off),
            .odd_sel(odd_sel),
            .rx_word(rx[k*LW +: LW]),
            .st_word(st),
            .tx_word(tx[k*LW +: LW]),
            .err_n  (err_n[k])
        );

        // R5
        tx_parity_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !par_off |-> (^tx[k*LW +: LW]) == odd_sel);
    end
endmodule

// File: rtl/parity_xcvr.sv
// Module: parity_xcvr (top)
// Two-way registered transceiver with two byte-plus-parity lanes per port. The
// A-to-B path drives B and checks A; the B-to-A path drives A and checks B.
// Assumes: rst_n is synchronous to both path clocks; three-state pins are split.
module parity_xcvr #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned LANES  = 2,
    localparam int unsigned PW    = LANES * (DATA_W + 1)
) (
    input  logic             rst_n,
    input  logic             ab_clk,
    input  logic             ab_le,
    input  logic [LANES-1:0] ab_ce_n,
    input  logic             ab_oe,
    input  logic             ba_clk,
    input  logic             ba_le,
    input  logic [LANES-1:0] ba_ce_n,
    input  logic             ba_oe,
    input  logic             par_off,
    input  logic             odd_sel,
    input  logic [PW-1:0]    a_in,
    input  logic [PW-1:0]    b_in,
    output logic [PW-1:0]    a_out,
    output logic             a_oe,
    output logic [PW-1:0]    b_out,
    output logic             b_oe,
    output logic [LANES-1:0] a_err_n,
    output logic [LANES-1:0] b_err_n,
    output logic             dir_conflict
);
    // A-to-B path: stores the A port, drives B, flags errors on A
    xcvr_dir #(.DW(DATA_W), .LANES(LANES)) u_ab (
        .clk    (ab_clk),
        .rst_n  (rst_n),
        .le     (ab_le),
        .ce_n   (ab_ce_n),
        .par_off(par_off),
        .odd_sel(odd_sel),
        .rx     (a_in),
        .tx     (b_out),
        .err_n  (a_err_n)
    );

    // B-to-A path: stores the B port, drives A, flags errors on B
    xcvr_dir #(.DW(DATA_W), .LANES(LANES)) u_ba (
        .clk    (ba_clk),
        .rst_n  (rst_n),
        .le     (ba_le),
        .ce_n   (ba_ce_n),
        .par_off(par_off),
        .odd_sel(odd_sel),
        .rx     (b_in),
        .tx     (a_out),
        .err_n  (b_err_n)
    );

    // Port enables: each port is driven by the path that ends at it
    assign b_oe         = ab_oe;
    assign a_oe         = ba_oe;
    assign dir_conflict = ab_oe & ba_oe;

    // R7
    bypass_no_err_chk: assert property (@(posedge ab_clk) disable iff (!rst_n)
        par_off |-> (&a_err_n && &b_err_n));
    // R9
    conflict_both_chk: assert property (@(posedge ab_clk) disable iff (!rst_n)
        dir_conflict |-> (a_oe && b_oe));
    // R8
    reset_err_idle_chk: assert property (@(posedge ab_clk)
        !rst_n |-> (&a_err_n && &b_err_n));
endmodule

// File: tb/parity_xcvr_bench.sv
module parity_xcvr_bench;
    logic        clk = 1'b0;
    logic        rst_n, ab_le, ba_le, ab_oe, ba_oe, par_off, odd_sel;
    logic [1:0]  ab_ce_n, ba_ce_n, a_err_n, b_err_n;
    logic [17:0] a_in, b_in, a_out, b_out;
    logic        a_oe, b_oe, dir_conflict;
    int          n_chk = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    parity_xcvr u_parity_xcvr (
        .rst_n(rst_n), .ab_clk(clk), .ab_le(ab_le), .ab_ce_n(ab_ce_n), .ab_oe(ab_oe),
        .ba_clk(clk), .ba_le(ba_le), .ba_ce_n(ba_ce_n), .ba_oe(ba_oe),
        .par_off(par_off), .odd_sel(odd_sel), .a_in(a_in), .b_in(b_in),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
        .a_err_n(a_err_n), .b_err_n(b_err_n), .dir_conflict(dir_conflict)
    );

    // {par_off, odd_sel, port word, expected far-side word, expected err_n}
    // port word = {p1, d1, p0, d0}, following the R1 lane layout
    localparam logic [39:0] VEC [0:6] = '{
        {1'b0, 1'b0, {1'b0,8'h03,1'b1,8'h01}, {1'b0,8'h03,1'b1,8'h01}, 2'b11},
        {1'b0, 1'b0, {1'b0,8'h03,1'b0,8'h01}, {1'b0,8'h03,1'b1,8'h01}, 2'b10},
        {1'b0, 1'b1, {1'b0,8'hFF,1'b0,8'h01}, {1'b1,8'hFF,1'b0,8'h01}, 2'b01},
        {1'b1, 1'b0, {1'b1,8'hFF,1'b0,8'h01}, {1'b1,8'hFF,1'b0,8'h01}, 2'b11},
        {1'b1, 1'b1, {1'b0,8'hA5,1'b1,8'h3C}, {1'b0,8'hA5,1'b1,8'h3C}, 2'b11},
        {1'b0, 1'b0, {1'b1,8'h00,1'b1,8'h00}, {1'b0,8'h00,1'b0,8'h00}, 2'b00},
        {1'b0, 1'b1, {1'b1,8'h00,1'b1,8'h00}, {1'b1,8'h00,1'b1,8'h00}, 2'b11}
    };

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ab_le = 1'b0; ba_le = 1'b0; ab_ce_n = 2'b00; ba_ce_n = 2'b00;
        ab_oe = 1'b0; ba_oe = 1'b0; par_off = 1'b0; odd_sel = 1'b0;
        a_in = {1'b0,8'h00,1'b1,8'h00}; b_in = '0;
        repeat (3) @(negedge clk);
        // R8: storage cleared, errors idle under reset despite bad parity
        check("R8 reset b_out", b_out, '0);
        check("R8 reset a_out", a_out, '0);
        check("R8 err idle in reset", {16'd0, a_err_n}, 18'd3);
        rst_n = 1'b1;
        #1 check("R6 lane0 error after reset", {16'd0, a_err_n}, 18'd2);

        // R1 R2 R5 R6 R7: transparent table through both directions
        ab_le = 1'b1; ba_le = 1'b1; ab_ce_n = 2'b11; ba_ce_n = 2'b11;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            {par_off, odd_sel, a_in} = VEC[i][39:20];
            b_in = a_in;
            #1;
            check("R2 R5 R7 b_out", b_out, VEC[i][19:2]);
            check("R2 R5 R7 a_out", a_out, VEC[i][19:2]);
            check("R6 a_err_n", {16'd0, a_err_n}, {16'd0, VEC[i][1:0]});
            check("R6 b_err_n", {16'd0, b_err_n}, {16'd0, VEC[i][1:0]});
        end

        // R3 R10: clocked load of A-to-B only
        @(negedge clk);
        ab_le = 1'b0; ba_le = 1'b0; par_off = 1'b1; odd_sel = 1'b0;
        ab_ce_n = 2'b00; ba_ce_n = 2'b11;
        a_in = {1'b1,8'h12,1'b0,8'h34}; b_in = 18'h3FFFF;
        #1 check("R2 no transparency with le low", b_out, {1'b1,8'h00,1'b1,8'h00});
        @(negedge clk);
        check("R3 load on edge", b_out, {1'b1,8'h12,1'b0,8'h34});
        check("R10 other path untouched", a_out, {1'b1,8'h00,1'b1,8'h00});

        // R4: lane 1 holds while lane 0 loads, then both hold
        ab_ce_n = 2'b10; a_in = {1'b0,8'h56,1'b1,8'h78};
        @(negedge clk);
        check("R4 per-lane hold", b_out, {1'b1,8'h12,1'b1,8'h78});
        ab_ce_n = 2'b11; a_in = {1'b0,8'h9A,1'b0,8'hBC};
        @(negedge clk);
        check("R4 full hold", b_out, {1'b1,8'h12,1'b1,8'h78});

        // R5: parity from the stored byte, not the live input
        par_off = 1'b0;
        #1 check("R5 even from stored", b_out, {1'b0,8'h12,1'b0,8'h78});
        odd_sel = 1'b1;
        #1 check("R5 odd from stored", b_out, {1'b1,8'h12,1'b1,8'h78});

        // R9: output enables and conflict
        @(negedge clk);
        ab_oe = 1'b1; ba_oe = 1'b0;
        #1 check("R9 one direction", {15'd0, b_oe, a_oe, dir_conflict}, 18'b100);
        ba_oe = 1'b1;
        #1 check("R9 conflict", {15'd0, b_oe, a_oe, dir_conflict}, 18'b111);

        // R8: reset in mid-run clears held storage
        odd_sel = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R8 mid-run clear b_out", b_out, '0);
        check("R8 mid-run clear a_out", a_out, '0);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule